// File: doc/BRIEF.md
# Profile-Pin Modulation Controller

This block turns a small bus of profile pins into the control word for one channel of a direct digital synthesizer. A local file holds up to sixteen 32-bit words. When the pins act as a level selector, they pick one of these words, which gives multi-level frequency, phase or amplitude keying. The word's meaning is set by the channel that consumes it. A 3-bit mode code sets how the pins are read. They can be a 2-, 4- or 16-way selector. They can drive the direction and hold inputs of a sweep accumulator. They can request an amplitude ramp. They can also be ignored, in which case the channel stays on entry 0.

The block runs on the quarter-rate sync clock. Pins and mode code are captured on one rising edge. The chosen word and the control flags are registered on the next rising edge. Only the value at a sampling edge matters, so pin activity between edges does not reach the channel. The file is loaded through a plain write port with an address and data.

Top module: `prof_mod_ctrl`

## Requirements
- R1: While reset is held, and after it is released until the first capture, `mod_word` is 0 and `sweep_up`, `sweep_hold` and `ramp_up` are 0.
- R2: A write with `wr_en` high at a rising edge stores `wr_data` at entry `wr_addr`. If that entry is selected, the new value shows on `mod_word` after the next rising edge, not the write edge itself.
- R3: Pins and mode are captured on a rising edge, and outputs follow on the next rising edge: a two-edge delay from a change set up before an edge.
- R4: Mode code 3'b011 selects the entry whose index equals the 4-bit pin value, pin 0 being the least significant bit.
- R5: Mode code 3'b001 selects entry 0 or 1 by pin 0 alone; pins 3..1 have no effect.
- R6: Mode code 3'b010 selects entries 0 to 3 by pins 1..0; pins 3..2 have no effect.
- R7: Mode code 3'b100 drives `sweep_up` from pin 0 (1 ramps up, 0 ramps down) and `sweep_hold` from pin 1 (1 stops the accumulator), with `mod_word` on entry 0.
- R8: Mode code 3'b101 drives `ramp_up` from pin 3, with `mod_word` on entry 0 and both sweep flags 0.
- R9: Mode codes 3'b000, 3'b110 and 3'b111 give single-tone behaviour: entry 0 on `mod_word`, all flags 0, pins ignored.
- R10: Pin changes that start and end between two rising edges have no effect on any output.
- R11: The pin bus may change at most once every two sync clocks; after a change it stays stable for at least the next edge.
- R12: `sweep_up` and `sweep_hold` are 0 outside mode 3'b100, and `ramp_up` is 0 outside mode 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock; all capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_pin | input | 4 | Profile pins |
| cfg_mode | input | 3 | Pin interpretation code |
| wr_en | input | 1 | Profile file write enable |
| wr_addr | input | 4 | Profile file write index |
| wr_data | input | 32 | Profile file write data |
| mod_word | output | 32 | Selected active word for the channel |
| sweep_up | output | 1 | Sweep direction request, 1 = upward |
| sweep_hold | output | 1 | Sweep stop request |
| ramp_up | output | 1 | Amplitude ramp request, 1 = ramp up, 0 = ramp down |

## Verification
The bench targets the upper pins in the 2- and 4-level modes. A decoder that passes them through would jump to entries 2 to 15. It checks that the undefined codes 3'b110 and 3'b111 hold entry 0; a decoder with a missing default would track the pins or leave stale flags. It also checks the exact edge at which a pin change or a write lands. A design with one register too few would move a cycle early, and one that forwarded write data would show the new word on the write edge itself. Finally, a pulse placed fully between edges must leave the word untouched, which catches a design that samples combinationally or on the wrong edge.

// File: rtl/prof_mod_pkg.sv
package prof_mod_pkg;

    // Pin interpretation codes (other codes fall back to single tone)
    localparam logic [2:0] CFG_TONE  = 3'b000;
    localparam logic [2:0] CFG_LVL2  = 3'b001;
    localparam logic [2:0] CFG_LVL4  = 3'b010;
    localparam logic [2:0] CFG_FULL  = 3'b011;
    localparam logic [2:0] CFG_SWEEP = 3'b100;
    localparam logic [2:0] CFG_RAMP  = 3'b101;

    typedef struct packed {
        logic up;
        logic hold;
        logic ramp;
    } ctl_flags_t;

endpackage

// File: rtl/prof_pin_decode.sv
module prof_pin_decode
    import prof_mod_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic [2:0]        cfg,
    input  logic [N_PINS-1:0] pins,
    output logic [N_PINS-1:0] sel,
    output ctl_flags_t        flags
);

    always_comb begin
        sel   = '0;
        flags = '0;
        case (cfg)
            CFG_LVL2:  sel[0]   = pins[0];
            CFG_LVL4:  sel[1:0] = pins[1:0];
            CFG_FULL:  sel      = pins;
            CFG_SWEEP: begin
                flags.up   = pins[0];
                flags.hold = pins[1];
            end
            CFG_RAMP:  flags.ramp = pins[N_PINS-1];
            default:   ;
        endcase
    end

endmodule

// File: rtl/prof_word_file.sv
module prof_word_file #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             hit;
    logic [DEPTH-1:0][WORD_W-1:0] ent_d, ent_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_hit
        assign hit[e] = wr_en && (wr_addr == ADDR_W'(e));
    end

    always_comb begin
        ent_d = ent_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (hit[e]) ent_d[e] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign rd_data = ent_q[rd_addr];

endmodule

// File: rtl/prof_mod_ctrl.sv
module prof_mod_ctrl
    import prof_mod_pkg::*;
#(
    parameter int N_PINS = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] prof_pin,
    input  logic [2:0]        cfg_mode,
    input  logic              wr_en,
    input  logic [N_PINS-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mod_word,
    output logic              sweep_up,
    output logic              sweep_hold,
    output logic              ramp_up
);

    typedef struct packed {
        logic [N_PINS-1:0] pin;
        logic [2:0]        cfg;
        logic [WORD_W-1:0] word;
        ctl_flags_t        flags;
    } state_t;

    state_t            st_d, st_q;
    logic [N_PINS-1:0] sel;
    ctl_flags_t        dec_flags;
    logic [WORD_W-1:0] rd_word;
    logic [N_PINS-1:0] pin_smp;
    logic [2:0]        cfg_smp;

    prof_pin_decode #(.N_PINS(N_PINS)) u_dec (
        .cfg   (st_q.cfg),
        .pins  (st_q.pin),
        .sel   (sel),
        .flags (dec_flags)
    );

    prof_word_file #(.WORD_W(WORD_W), .ADDR_W(N_PINS)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (sel),
        .rd_data (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pin   = prof_pin;
        st_d.cfg   = cfg_mode;
        st_d.word  = rd_word;
        st_d.flags = dec_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mod_word   = st_q.word;
    assign sweep_up   = st_q.flags.up;
    assign sweep_hold = st_q.flags.hold;
    assign ramp_up    = st_q.flags.ramp;
    assign pin_smp    = st_q.pin;
    assign cfg_smp    = st_q.cfg;

endmodule

// File: rtl/prof_mod_chk.sv
module prof_mod_chk
    import prof_mod_pkg::*;
#(
    parameter int N_PINS = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] prof_pin,
    input logic              wr_en,
    input logic [N_PINS-1:0] pin_smp,
    input logic [2:0]        cfg_smp,
    input logic [WORD_W-1:0] mod_word,
    input logic              sweep_up,
    input logic              sweep_hold,
    input logic              ramp_up
);

    // R11: after a pin change the bus holds for the next edge
    p_pin_rate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_pin != $past(prof_pin)) |=> $stable(prof_pin));

    // R3: unchanged captured inputs and no writes keep the word steady
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$past(wr_en) && $stable(pin_smp) && $stable(cfg_smp))
        |=> $stable(mod_word));

    // R12: sweep flags only in sweep mode
    p_sweep_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_smp != CFG_SWEEP) |=> (!sweep_up && !sweep_hold));

    // R12: ramp request only in ramp mode
    p_ramp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_smp != CFG_RAMP) |=> !ramp_up);

    // R8: a ramp request never coexists with sweep flags
    p_ramp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up |-> (!sweep_up && !sweep_hold));

endmodule

bind prof_mod_ctrl prof_mod_chk #(.N_PINS(N_PINS), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prof_pin   (prof_pin),
    .wr_en      (wr_en),
    .pin_smp    (pin_smp),
    .cfg_smp    (cfg_smp),
    .mod_word   (mod_word),
    .sweep_up   (sweep_up),
    .sweep_hold (sweep_hold),
    .ramp_up    (ramp_up)
);

// File: tb/tb_prof_mod_ctrl.sv
`timescale 1ns/1ps
module tb_prof_mod_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  prof_pin = '0;
    logic [2:0]  cfg_mode = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] mod_word;
    logic        sweep_up, sweep_hold, ramp_up;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_ent [16];

    always #10 clk = ~clk;

    prof_mod_ctrl dut (
        .clk(clk), .rst_n(rst_n), .prof_pin(prof_pin), .cfg_mode(cfg_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mod_word(mod_word), .sweep_up(sweep_up), .sweep_hold(sweep_hold),
        .ramp_up(ramp_up)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drive pins/mode at a falling edge, then wait for the two-edge delay
    task automatic apply(input logic [2:0] m, input logic [3:0] p);
        cfg_mode = m;
        prof_pin = p;
        step();
        step();
    endtask

    task automatic check_flags(input string req, input logic u, input logic h, input logic r);
        check(req, {29'd0, sweep_up, sweep_hold, ramp_up}, {29'd0, u, h, r});
    endtask

    task automatic t_reset();
        check("R1 word", mod_word, 32'h0);
        check_flags("R1 flags", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_load();
        for (int i = 0; i < 16; i++) begin
            exp_ent[i] = 32'h5A00_0000 + 32'(i) * 32'h0013_0907 + 32'h11;
            wr_en   = 1'b1;
            wr_addr = 4'(i);
            wr_data = exp_ent[i];
            step();
        end
        wr_en = 1'b0;
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) begin
            apply(3'b011, 4'(i));
            check("R4 index", mod_word, exp_ent[i]);
            check_flags("R12 full flags", 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_lvl2();
        apply(3'b001, 4'b1110);
        check("R5 upper ignored", mod_word, exp_ent[0]);
        apply(3'b001, 4'b0001);
        check("R5 pin0", mod_word, exp_ent[1]);
        apply(3'b001, 4'b1111);
        check("R5 all high", mod_word, exp_ent[1]);
    endtask

    task automatic t_lvl4();
        apply(3'b010, 4'b1110);
        check("R6 sel 2", mod_word, exp_ent[2]);
        apply(3'b010, 4'b0111);
        check("R6 sel 3", mod_word, exp_ent[3]);
        apply(3'b010, 4'b1100);
        check("R6 sel 0", mod_word, exp_ent[0]);
    endtask

    task automatic t_sweep();
        apply(3'b100, 4'b0001);
        check_flags("R7 up", 1'b1, 1'b0, 1'b0);
        check("R7 word", mod_word, exp_ent[0]);
        apply(3'b100, 4'b1010);
        check_flags("R7 hold down", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_ramp();
        apply(3'b101, 4'b1000);
        check_flags("R8 ramp", 1'b0, 1'b0, 1'b1);
        check("R8 word", mod_word, exp_ent[0]);
        apply(3'b101, 4'b0111);
        check_flags("R8 ramp down", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_tone();
        apply(3'b100, 4'b0011);
        apply(3'b110, 4'b1111);
        check("R9 code 6", mod_word, exp_ent[0]);
        check_flags("R9 code 6 flags", 1'b0, 1'b0, 1'b0);
        apply(3'b111, 4'b0101);
        check("R9 code 7", mod_word, exp_ent[0]);
        apply(3'b000, 4'b1001);
        check("R9 code 0", mod_word, exp_ent[0]);
        check_flags("R12 tone flags", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_latency();
        apply(3'b011, 4'd4);
        prof_pin = 4'd7;
        step();
        check("R3 one edge", mod_word, exp_ent[4]);
        step();
        check("R3 two edges", mod_word, exp_ent[7]);
    endtask

    task automatic t_write();
        apply(3'b011, 4'd5);
        wr_en   = 1'b1;
        wr_addr = 4'd5;
        wr_data = 32'hDEAD_BEEF;
        step();
        wr_en = 1'b0;
        check("R2 write edge", mod_word, exp_ent[5]);
        exp_ent[5] = 32'hDEAD_BEEF;
        step();
        check("R2 next edge", mod_word, exp_ent[5]);
    endtask

    task automatic t_glitch();
        apply(3'b011, 4'd2);
        for (int k = 0; k < 2; k++) begin
            #3 prof_pin = 4'd9;
            #4 prof_pin = 4'd2;
            step();
            check("R10 glitch", mod_word, exp_ent[2]);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_load();
        t_full();
        t_lvl2();
        t_lvl4();
        t_sweep();
        t_ramp();
        t_tone();
        t_latency();
        t_write();
        t_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule